// File: doc/BRIEF.md
# Parallel-Compression Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Every partial-product bit comes from one AND gate. The resulting N rows are then shrunk in parallel stages built from 3:2 counters. Each stage splits the rows into groups of three, and each group becomes one sum row and one carry row, with the carry row shifted one place up. Any rows that do not fill a group of three pass through that stage unchanged. A row count r therefore becomes 2*floor(r/3) + (r mod 3) after each stage. The stages repeat until only two rows are left. So the default of eight rows takes four stages: 8, 6, 4, 3, 2.

A carry-lookahead adder sums the two remaining rows. The adder is made of 4-bit lookahead groups, and the carry passes from one group to the next. The operand width does not have to fill the last group; the unused bits are padded with zeros. A parameter selects one of two output modes. In the first, a register on the product output adds one clock of latency. In the second, the output is purely combinational and ignores the clock and the reset.

Top module: `wal_mult`

## Requirements
- R1: `prod_o` equals `mcand_i * mplier_i`, taken as unsigned integers and given over the full 2N bits, for every pair of operands.
- R2: When either operand is zero the product is zero. When both operands are all ones the product is (2^N-1)^2, which sets the top product bit.
- R3: The two rows left after compression add up, modulo 2^(2N), to the true product.
- R4: The lookahead adder returns the exact 2N-bit sum of the two remaining rows. This holds for an N whose 2N is not a multiple of four (N=5).
- R5: With `REG_OUT=1`, the product of the operands present at a rising edge of `clk_i` appears on `prod_o` after that edge. It then holds until the next edge.
- R6: With `REG_OUT=1`, driving `rst_ni` low forces `prod_o` to zero at once, without waiting for a clock edge.
- R7: With `REG_OUT=0`, `prod_o` follows the operands combinationally. Holding `rst_ni` low has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| mcand_i | input | N | Unsigned multiplicand |
| mplier_i | input | N | Unsigned multiplier |
| prod_o | output | 2N | Unsigned product |

## Verification
The bench runs every operand pair of the registered 8-bit build, so it covers the all-ones case. A design that loses the carry out of the top column, or that drops a shifted carry row, gives that case the wrong upper bits. An unregistered 5-bit build is also swept exhaustively. In that build the final adder ends in a partial lookahead group, which exposes a padding or group carry-chain fault as errors in the high bits only. A reset pulse between clock edges checks that the output clears without waiting for an edge. The unregistered build is checked while reset is held low, so a design that wrongly gates it with reset returns zeros.

// File: rtl/wal_pkg.sv
package wal_pkg;
  function automatic int next_rows(input int r);
    return (r <= 2) ? r : 2 * (r / 3) + (r % 3);
  endfunction

  function automatic int rows_at(input int r0, input int s);
    int r;
    r = r0;
    for (int k = 0; k < s; k++) r = next_rows(r);
    return r;
  endfunction

  function automatic int num_stages(input int r0);
    int r;
    int s;
    r = r0;
    s = 0;
    while (r > 2) begin
      r = next_rows(r);
      s++;
    end
    return s;
  endfunction
endpackage

// File: rtl/wal_pp_gen.sv
module wal_pp_gen #(
  parameter int N    = 8,
  parameter int RMAX = 8,
  localparam int W   = 2 * N
) (
  input  logic [N-1:0]           a_i,
  input  logic [N-1:0]           b_i,
  output logic [RMAX-1:0][W-1:0] rows_o
);
  for (genvar i = 0; i < RMAX; i++) begin : g_row
    if (i < N) begin : g_live
      logic [N-1:0] bits;
      assign bits = a_i & {N{b_i[i]}};
      assign rows_o[i] = W'(bits) << i;
    end else begin : g_pad
      assign rows_o[i] = '0;
    end
  end
endmodule

// File: rtl/wal_csa_stage.sv
module wal_csa_stage #(
  parameter int W    = 16,
  parameter int RIN  = 8,
  parameter int RMAX = 8,
  localparam int GRP  = RIN / 3,
  localparam int ROUT = 2 * GRP + (RIN % 3)
) (
  input  logic [RMAX-1:0][W-1:0] rows_i,
  output logic [RMAX-1:0][W-1:0] rows_o
);
  for (genvar i = 0; i < RMAX; i++) begin : g_out
    if (i < 2 * GRP) begin : g_csa
      localparam int B = 3 * (i / 2);
      logic [W-1:0] x, y, z;
      assign x = rows_i[B];
      assign y = rows_i[B+1];
      assign z = rows_i[B+2];
      if (i % 2 == 0) begin : g_sum
        assign rows_o[i] = x ^ y ^ z;
      end else begin : g_cry
        // carry moves one column up; top carry is beyond the product width
        assign rows_o[i] = ((x & y) | (x & z) | (y & z)) << 1;
      end
    end else if (i < ROUT) begin : g_pass
      assign rows_o[i] = rows_i[3 * GRP + i - 2 * GRP];
    end else begin : g_zero
      assign rows_o[i] = '0;
    end
  end
endmodule

// File: rtl/wal_cla4.sv
module wal_cla4 (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_i,
  output logic [3:0] s_o,
  output logic       c_o
);
  logic [3:0] g, p;
  logic [4:0] c;
  assign g = a_i & b_i;
  assign p = a_i ^ b_i;
  assign c[0] = c_i;
  assign c[1] = g[0] | (p[0] & c_i);
  assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_i);
  assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c_i);
  assign c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
              | (&p & c_i);
  assign s_o = p ^ c[3:0];
  assign c_o = c[4];
endmodule

// File: rtl/wal_cla.sv
module wal_cla #(
  parameter int W  = 16,
  localparam int NG = (W + 3) / 4,
  localparam int WP = 4 * NG
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [WP-1:0] ap, bp, sp;
  logic [NG:0]   gc;
  assign ap = WP'(a_i);
  assign bp = WP'(b_i);
  assign gc[0] = 1'b0;
  for (genvar g = 0; g < NG; g++) begin : g_grp
    wal_cla4 u_grp (
      .a_i(ap[4*g +: 4]),
      .b_i(bp[4*g +: 4]),
      .c_i(gc[g]),
      .s_o(sp[4*g +: 4]),
      .c_o(gc[g+1])
    );
  end
  assign s_o = sp[W-1:0];
endmodule

// File: rtl/wal_mult.sv
module wal_mult #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int W    = 2 * N,
  localparam int RMAX = (N < 2) ? 2 : N,
  localparam int NS   = wal_pkg::num_stages(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic [W-1:0] prod_o
);
  logic [RMAX-1:0][W-1:0] lvl [NS+1];
  logic [W-1:0] sum;

  wal_pp_gen #(.N(N), .RMAX(RMAX)) u_pp (
    .a_i(mcand_i), .b_i(mplier_i), .rows_o(lvl[0])
  );

  for (genvar s = 0; s < NS; s++) begin : g_stage
    wal_csa_stage #(.W(W), .RIN(wal_pkg::rows_at(N, s)), .RMAX(RMAX)) u_stg (
      .rows_i(lvl[s]), .rows_o(lvl[s+1])
    );
  end

  wal_cla #(.W(W)) u_add (
    .a_i(lvl[NS][0]), .b_i(lvl[NS][1]), .s_o(sum)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_o <= '0;
      else         prod_o <= sum;
    end

    a_r5_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> prod_o == $past(W'(mcand_i) * W'(mplier_i)));
    a_r6_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> prod_o == '0);
  end else begin : g_comb
    assign prod_o = sum;
  end

  a_r3_two_rows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    W'(lvl[NS][0] + lvl[NS][1]) == W'(W'(mcand_i) * W'(mplier_i)));
  a_r4_final_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum == W'(lvl[NS][0] + lvl[NS][1]));
  a_r2_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcand_i == '0 || mplier_i == '0) |-> sum == '0);
endmodule

// File: tb/sim_wal_mult.sv
module sim_wal_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [9:0]  p5;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wal_mult #(.N(8), .REG_OUT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mcand_i(a8), .mplier_i(b8), .prod_o(p8)
  );
  wal_mult #(.N(5), .REG_OUT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .mcand_i(a8[4:0]), .mplier_i(b8[4:0]), .prod_o(p5)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    // reset state; R7 combinational build unaffected by reset
    #1;
    chk("R6 reset", p8, 16'h0);
    a8 = 8'd7; b8 = 8'd9;
    #1;
    chk("R7 comb under reset", {6'b0, p5}, 16'd63);
    @(posedge clk); #1;
    chk("R6 held in reset", p8, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R2/R4/R5 exhaustive sweep
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        a8 = 8'(i); b8 = 8'(j);
        #0.5;
        chk("R4 R7 N=5 comb", {6'b0, p5}, 16'((i % 32) * (j % 32)));
        @(posedge clk); #1;
        if (i == 0 || j == 0)           chk("R2 zero", p8, 16'h0);
        else if (i == 255 && j == 255)  chk("R2 all ones", p8, 16'hFE01);
        else                            chk("R1 R5 product", p8, 16'(i * j));
      end
    end

    // R5 hold between edges
    @(negedge clk);
    a8 = 8'd13; b8 = 8'd11;
    @(posedge clk); #1;
    a8 = 8'd3; b8 = 8'd3;
    #1;
    chk("R5 hold", p8, 16'd143);
    @(posedge clk); #1;
    chk("R5 update", p8, 16'd9);

    // R6 asynchronous clear away from an edge
    @(negedge clk); #0.5;
    rst_n = 1'b0;
    #0.5;
    chk("R6 async clear", p8, 16'h0);
    chk("R7 comb under reset", {6'b0, p5}, 16'd9);
    @(negedge clk); rst_n = 1'b1;
    a8 = 8'd200; b8 = 8'd150;
    @(posedge clk); #1;
    chk("R1 after reset", p8, 16'd30000);

    done = 1'b1;
    finish_run();
  end
endmodule